// File: doc/BRIEF.md
# Multi-Mode Stepper Coil Sequencer

This block produces the four coil enables for a stepper motor. An internal eight-position position counter moves one position per clock while stepping is enabled. It counts up or down depending on a direction input. A two-bit mode input selects how the counter position is turned into a coil pattern: one coil at a time, two adjacent coils at a time, or half steps that alternate between the two. A fourth mode ignores the counter and forwards a four-bit direct coil word to the outputs.

The coil outputs are registered, so all four coils change together on a clock edge. In the three counter modes, the registered pattern is decoded from the counter value that the same edge produces. The pattern and the position therefore always belong to each other. A separate step-rate generator drives the step enable. The power stage sits behind the coil outputs.

Top module: `stepper_sequencer`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the position counter to 0 and the coil outputs to 4'b0000. Reset takes priority over every other input, including the direct mode.
- R2: When `step_en` is low at an edge, the position counter keeps its value.
- R3: When `step_en` is high in a counter mode (mode 0, 1 or 2), the position changes by one at each edge. It counts up when `dir_up` is 1, wrapping from 7 to 0, and counts down when `dir_up` is 0, wrapping from 0 to 7.
- R4: Mode 0 (single-coil wave) drives coil bit k, with k = position mod 4. The patterns are 0001, 0010, 0100, 1000 for k = 0..3.
- R5: Mode 1 (two-coil full step) drives coil bits k and (k+1) mod 4, with k = position mod 4. The patterns are 0011, 0110, 1100, 1001 for k = 0..3.
- R6: Mode 2 (half step) uses all eight positions p and drives these patterns for p = 0..7: 0001, 0011, 0010, 0110, 0100, 1100, 1000, 1001. Even positions energise one coil and odd positions energise two.
- R7: In mode 3 (direct), the coil outputs take the value of `direct_coils` at the next edge. In this mode the position counter holds its value whatever `step_en` and `dir_up` are.
- R8: In mode 0, each step turns exactly one coil off and one other coil on at the same edge.
- R9: The coil outputs update at each edge from the mode and position of that edge. A change of `mode_sel` with no step therefore re-decodes the held position at the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_en | input | 1 | Advance the position at this edge |
| dir_up | input | 1 | 1 = count up, 0 = count down |
| mode_sel | input | 2 | 0 wave, 1 full step, 2 half step, 3 direct |
| direct_coils | input | 4 | Coil word forwarded in mode 3 |
| coil_drive | output | 4 | Registered coil enables, bit 0 = first coil |

## Verification
On every cycle, the assertions check the following:
- the counter's hold behaviour and its ±1 wrapping step;
- the number of coils energised in each counter mode, tied to the position's parity in half step;
- the one-edge copy of the direct word, together with the frozen counter in direct mode;
- the two-bit change between successive wave patterns.

The exact coil pattern at each position, in both directions, comes only from the bench's vector walk. The same holds for return from direct mode to the held position, for re-decoding on a mode change without a step, and for reset taking priority over direct mode.

// File: rtl/stepper_pkg.sv
package stepper_pkg;

    localparam int COIL_N  = 4;
    localparam int PHASE_W = $clog2(COIL_N);
    localparam int STEP_N  = 2 * COIL_N;
    localparam int STEP_W  = $clog2(STEP_N);
    localparam int MODE_N  = 4;
    localparam int MODE_W  = $clog2(MODE_N);

    typedef logic [COIL_N-1:0]  coil_t;
    typedef logic [PHASE_W-1:0] phase_t;
    typedef logic [STEP_W-1:0]  step_t;

    typedef enum logic [MODE_W-1:0] {
        MODE_WAVE   = 2'd0,
        MODE_FULL   = 2'd1,
        MODE_HALF   = 2'd2,
        MODE_DIRECT = 2'd3
    } drive_mode_e;

    typedef struct packed {
        logic        step_en;
        logic        dir_up;
        drive_mode_e mode;
        coil_t       direct;
    } ctrl_t;

    // one energised coil at phase k
    function automatic coil_t single_coil(input phase_t k);
        coil_t r;
        r    = '0;
        r[k] = 1'b1;
        return r;
    endfunction

    // coil k plus its neighbour, wrapping past the last coil
    function automatic coil_t pair_coil(input phase_t k);
        coil_t  r;
        phase_t nxt;
        nxt    = k + phase_t'(1);
        r      = '0;
        r[k]   = 1'b1;
        r[nxt] = 1'b1;
        return r;
    endfunction

    function automatic coil_t half_coil(input step_t s);
        phase_t k;
        k = s[STEP_W-1:1];
        return s[0] ? pair_coil(k) : single_coil(k);
    endfunction

endpackage

// File: rtl/step_counter.sv
module step_counter
    import stepper_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  advance,
    input  logic  dir_up,
    output step_t cnt_d,
    output step_t cnt_q
);

    always_comb begin
        if (rst)
            cnt_d = '0;
        else if (advance)
            cnt_d = dir_up ? cnt_q + step_t'(1) : cnt_q - step_t'(1);
        else
            cnt_d = cnt_q;
    end

    always_ff @(posedge clk) begin
        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/coil_decoder.sv
module coil_decoder
    import stepper_pkg::*;
(
    input  step_t       step,
    input  drive_mode_e mode,
    input  coil_t       direct,
    output coil_t       pattern
);

    coil_t by_mode [MODE_N];

    for (genvar m = 0; m < MODE_N; m++) begin : g_mode
        if (m == int'(MODE_WAVE)) begin : g_wave
            assign by_mode[m] = single_coil(step[PHASE_W-1:0]);
        end else if (m == int'(MODE_FULL)) begin : g_full
            assign by_mode[m] = pair_coil(step[PHASE_W-1:0]);
        end else if (m == int'(MODE_HALF)) begin : g_half
            assign by_mode[m] = half_coil(step);
        end else begin : g_direct
            assign by_mode[m] = direct;
        end
    end

    assign pattern = by_mode[mode];

endmodule

// File: rtl/coil_register.sv
module coil_register
    import stepper_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  coil_t next_coils,
    output coil_t coils_q
);

    always_ff @(posedge clk) begin
        if (rst)
            coils_q <= '0;
        else
            coils_q <= next_coils;
    end

endmodule

// File: rtl/stepper_sequencer.sv
module stepper_sequencer
    import stepper_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              step_en,
    input  logic              dir_up,
    input  logic [MODE_W-1:0] mode_sel,
    input  logic [COIL_N-1:0] direct_coils,
    output logic [COIL_N-1:0] coil_drive
);

    ctrl_t ctrl;
    step_t count_d;
    step_t count_q;
    coil_t pattern;
    coil_t coils_q;
    logic  advance;

    assign ctrl.step_en = step_en;
    assign ctrl.dir_up  = dir_up;
    assign ctrl.mode    = drive_mode_e'(mode_sel);
    assign ctrl.direct  = direct_coils;

    // the position is frozen while the counter is bypassed
    assign advance = ctrl.step_en && (ctrl.mode != MODE_DIRECT);

    step_counter u_counter (
        .clk     (clk),
        .rst     (rst),
        .advance (advance),
        .dir_up  (ctrl.dir_up),
        .cnt_d   (count_d),
        .cnt_q   (count_q)
    );

    // decode the position this edge will produce, so the pattern and the position line up
    coil_decoder u_decoder (
        .step    (count_d),
        .mode    (ctrl.mode),
        .direct  (ctrl.direct),
        .pattern (pattern)
    );

    coil_register u_outreg (
        .clk        (clk),
        .rst        (rst),
        .next_coils (pattern),
        .coils_q    (coils_q)
    );

    assign coil_drive = coils_q;

endmodule

// File: rtl/stepper_sequencer_chk.sv
module stepper_sequencer_chk
    import stepper_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              step_en,
    input logic              dir_up,
    input logic [MODE_W-1:0] mode_sel,
    input logic [COIL_N-1:0] direct_coils,
    input logic [COIL_N-1:0] coil_drive,
    input step_t             count_q
);

    logic past_rst_q = 1'b0;
    always_ff @(posedge clk) past_rst_q <= rst;

    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
        past_rst_q |-> (coil_drive == '0 && count_q == '0));

    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !step_en |=> $stable(count_q));

    assert_count_up_R3: assert property (@(posedge clk) disable iff (rst)
        (step_en && dir_up && mode_sel != 2'd3) |=> count_q == step_t'($past(count_q) + step_t'(1)));

    assert_count_down_R3: assert property (@(posedge clk) disable iff (rst)
        (step_en && !dir_up && mode_sel != 2'd3) |=> count_q == step_t'($past(count_q) - step_t'(1)));

    assert_wave_one_coil_R4: assert property (@(posedge clk) disable iff (rst)
        mode_sel == 2'd0 |=> $countones(coil_drive) == 1);

    assert_full_two_coils_R5: assert property (@(posedge clk) disable iff (rst)
        mode_sel == 2'd1 |=> $countones(coil_drive) == 2);

    assert_half_parity_R6: assert property (@(posedge clk) disable iff (rst)
        mode_sel == 2'd2 |=> $countones(coil_drive) == (count_q[0] ? 2 : 1));

    assert_direct_copy_R7: assert property (@(posedge clk) disable iff (rst)
        mode_sel == 2'd3 |=> (coil_drive == $past(direct_coils) && $stable(count_q)));

    assert_wave_swap_R8: assert property (@(posedge clk) disable iff (rst)
        (mode_sel == 2'd0 && $past(mode_sel) == 2'd0 && !$past(rst) && step_en)
        |=> $countones(coil_drive ^ $past(coil_drive)) == 2);

endmodule

bind stepper_sequencer stepper_sequencer_chk u_chk (.*);

// File: tb/tb_stepper_sequencer.sv
`timescale 1ns/100ps
module tb_stepper_sequencer;

    logic       clk = 1'b0;
    logic       rst;
    logic       step_en;
    logic       dir_up;
    logic [1:0] mode_sel;
    logic [3:0] direct_coils;
    logic [3:0] coil_drive;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    stepper_sequencer dut (
        .clk          (clk),
        .rst          (rst),
        .step_en      (step_en),
        .dir_up       (dir_up),
        .mode_sel     (mode_sel),
        .direct_coils (direct_coils),
        .coil_drive   (coil_drive)
    );

    // {req[3:0], rst, step_en, dir_up, mode[1:0], direct[3:0], expected[3:0]}
    localparam int NVEC = 32;
    localparam logic [16:0] VEC [NVEC] = '{
        {4'd1, 1'b1, 1'b0, 1'b1, 2'd0, 4'h0, 4'b0000}, // R1 reset: position 0
        {4'd4, 1'b0, 1'b1, 1'b1, 2'd0, 4'h0, 4'b0010}, // R4 pos 1
        {4'd4, 1'b0, 1'b1, 1'b1, 2'd0, 4'h0, 4'b0100}, // R4 pos 2
        {4'd4, 1'b0, 1'b1, 1'b1, 2'd0, 4'h0, 4'b1000}, // R4 pos 3
        {4'd4, 1'b0, 1'b1, 1'b1, 2'd0, 4'h0, 4'b0001}, // R4 pos 4
        {4'd3, 1'b0, 1'b1, 1'b0, 2'd0, 4'h0, 4'b1000}, // R3 down: pos 3
        {4'd3, 1'b0, 1'b1, 1'b0, 2'd0, 4'h0, 4'b0100}, // R3 pos 2
        {4'd2, 1'b0, 1'b0, 1'b0, 2'd0, 4'h0, 4'b0100}, // R2 hold pos 2
        {4'd9, 1'b0, 1'b0, 1'b1, 2'd1, 4'h0, 4'b1100}, // R9 re-decode pos 2 as full step
        {4'd5, 1'b0, 1'b1, 1'b1, 2'd1, 4'h0, 4'b1001}, // R5 pos 3
        {4'd5, 1'b0, 1'b1, 1'b1, 2'd1, 4'h0, 4'b0011}, // R5 pos 4
        {4'd5, 1'b0, 1'b1, 1'b1, 2'd1, 4'h0, 4'b0110}, // R5 pos 5
        {4'd5, 1'b0, 1'b1, 1'b0, 2'd1, 4'h0, 4'b0011}, // R5 down pos 4
        {4'd9, 1'b0, 1'b0, 1'b1, 2'd2, 4'h0, 4'b0100}, // R9 half step of pos 4
        {4'd6, 1'b0, 1'b1, 1'b1, 2'd2, 4'h0, 4'b1100}, // R6 pos 5
        {4'd6, 1'b0, 1'b1, 1'b1, 2'd2, 4'h0, 4'b1000}, // R6 pos 6
        {4'd6, 1'b0, 1'b1, 1'b1, 2'd2, 4'h0, 4'b1001}, // R6 pos 7
        {4'd3, 1'b0, 1'b1, 1'b1, 2'd2, 4'h0, 4'b0001}, // R3 wrap 7 -> 0
        {4'd6, 1'b0, 1'b1, 1'b1, 2'd2, 4'h0, 4'b0011}, // R6 pos 1
        {4'd6, 1'b0, 1'b1, 1'b1, 2'd2, 4'h0, 4'b0010}, // R6 pos 2
        {4'd6, 1'b0, 1'b1, 1'b1, 2'd2, 4'h0, 4'b0110}, // R6 pos 3
        {4'd6, 1'b0, 1'b1, 1'b1, 2'd2, 4'h0, 4'b0100}, // R6 pos 4
        {4'd6, 1'b0, 1'b1, 1'b0, 2'd2, 4'h0, 4'b0110}, // R6 down pos 3
        {4'd6, 1'b0, 1'b1, 1'b0, 2'd2, 4'h0, 4'b0010}, // R6 down pos 2
        {4'd7, 1'b0, 1'b1, 1'b1, 2'd3, 4'hA, 4'b1010}, // R7 direct copy
        {4'd7, 1'b0, 1'b1, 1'b0, 2'd3, 4'h5, 4'b0101}, // R7 direct copy
        {4'd7, 1'b0, 1'b1, 1'b1, 2'd3, 4'hF, 4'b1111}, // R7 all coils
        {4'd7, 1'b0, 1'b0, 1'b1, 2'd3, 4'h0, 4'b0000}, // R7 no coils
        {4'd7, 1'b0, 1'b0, 1'b1, 2'd2, 4'h0, 4'b0010}, // R7 position 2 held through direct mode
        {4'd1, 1'b1, 1'b1, 1'b1, 2'd2, 4'h0, 4'b0000}, // R1 reset mid-run
        {4'd1, 1'b0, 1'b0, 1'b1, 2'd2, 4'h0, 4'b0001}, // R1 position back to 0
        {4'd3, 1'b0, 1'b1, 1'b0, 2'd0, 4'h0, 4'b1000}  // R3 wrap 0 -> 7
    };

    task automatic check(input int req, input logic [3:0] got, input logic [3:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL R%0d: coil_drive=%b expected=%b", req, got, exp);
        end
    endtask

    task automatic apply(input logic r, input logic en, input logic up,
                         input logic [1:0] m, input logic [3:0] d);
        rst = r; step_en = en; dir_up = up; mode_sel = m; direct_coils = d;
        @(negedge clk);
    endtask

    initial begin
        rst = 1'b1; step_en = 1'b0; dir_up = 1'b1; mode_sel = 2'd0; direct_coils = '0;
        @(negedge clk);
        @(negedge clk);
        for (int i = 0; i < NVEC; i++) begin
            apply(VEC[i][12], VEC[i][11], VEC[i][10], VEC[i][9:8], VEC[i][7:4]);
            check(int'(VEC[i][16:13]), coil_drive, VEC[i][3:0]);
        end

        // R1: reset wins over direct mode
        apply(1'b1, 1'b1, 1'b1, 2'd3, 4'hF);
        check(1, coil_drive, 4'b0000);

        // R8: successive wave steps swap exactly one coil for another
        apply(1'b0, 1'b0, 1'b1, 2'd0, 4'h0);
        check(8, coil_drive, 4'b0001);
        for (int s = 0; s < 9; s++) begin
            logic [3:0] prev;
            prev = coil_drive;
            apply(1'b0, 1'b1, (s < 5), 2'd0, 4'h0);
            check(8, 4'(($countones(coil_drive ^ prev) == 2) && ($countones(coil_drive) == 1)), 4'd1);
        end

        // R2: a long idle keeps the pattern
        apply(1'b0, 1'b0, 1'b0, 2'd1, 4'h0);
        begin
            logic [3:0] held;
            held = coil_drive;
            for (int s = 0; s < 5; s++) begin
                apply(1'b0, 1'b0, 1'b0, 2'd1, 4'h0);
                check(2, coil_drive, held);
            end
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #50000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run hung, got=timeout expected=completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule